// File: doc/BRIEF.md
# Dual-Band Multimodulus Prescaler

This block divides a fast input clock by one of four ratios: 32, 33, 47 or 48. It is the first counting stage of an integer-N frequency divider. A following counter clocks on its terminal pulse and steers the modulus input, which gives pulse-swallow division.

Inside, a stage that divides by two or three feeds a counter of sixteen stage cycles. A gate on that counter's state and the modulus input drives the stage's mode line. A band-select input can invert that mode line. The same sixteen-cycle structure therefore gives the 32/33 pair in the low band and the 47/48 pair in the high band, with no extra state.

Both settings are captured once per output period at its boundary. A change therefore never produces a period that mixes two ratios.

Top module: `dual_band_prescaler`

## Requirements
- R1: With band_sel=0 and mod_sel=1, one output period spans 32 input clocks: sixteen stage cycles of two clocks each.
- R2: With band_sel=0 and mod_sel=0, one output period spans 33 input clocks: fifteen stage cycles of two clocks and a final cycle of three.
- R3: With band_sel=1 and mod_sel=0, one output period spans 47 input clocks: fifteen stage cycles of three clocks and a final cycle of two.
- R4: With band_sel=1 and mod_sel=1, one output period spans 48 input clocks: sixteen stage cycles of three clocks each.
- R5: tc_pulse is 1 for exactly one input clock per period, the last one, and is 0 in the first clock of the next period.
- R6: div_clk is 0 during the first eight stage cycles of a period and 1 during the last eight. That gives 16 low clocks per period in the low band (band_sel=0) and 24 in the high band (band_sel=1).
- R7: band_sel and mod_sel are sampled only at the clock edge that ends a period, while tc_pulse is 1. A change at any other time has no effect on the current period's length.
- R8: rst is synchronous and active high. While it is held, tc_pulse and div_clk are 0. The settings present at the last clock edge with rst=1 govern the first period, which begins in the clock after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| band_sel | input | 1 | 0 selects the 32/33 pair, 1 selects the 47/48 pair |
| mod_sel | input | 1 | Modulus choice within the selected pair |
| div_clk | output | 1 | Divided clock, low in the first half of the stage cycles |
| tc_pulse | output | 1 | One-clock pulse on the last input clock of each period |

## Verification
The assertions assume that rst is held for at least one clock edge before any period is measured. The period-length property relies on the settings being captured only at the boundary, so it compares against the captured values and not the live inputs.

The stimulus changes band_sel and mod_sel in the clock where tc_pulse is 1, so that each new setting is sampled at the terminal edge. Some periods receive a deliberate mid-period change, which the next boundary write overrides, so the captured value is always known. Reset is applied only away from a terminal clock. It is held for several edges with the intended settings already present.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

   // Input-clock count of one output period for a band/modulus choice,
   // with CYCLES stage cycles per period.
   function automatic int ratio(input logic band, input logic modv, input int cycles);
      int r;
      if (band) r = modv ? 3 * cycles : 3 * cycles - 1;
      else      r = modv ? 2 * cycles : 2 * cycles + 1;
      return r;
   endfunction

endpackage

// File: rtl/dbp_stage23.sv
// Stage that divides by two or three input clocks per cycle.
module dbp_stage23 (
   input  logic clk,
   input  logic rst,
   input  logic div2,       // 1: two-clock cycle, 0: three-clock cycle
   output logic cyc_end     // last input clock of the current stage cycle
);
   logic [1:0] ph;

   assign cyc_end = div2 ? (ph == 2'd1) : (ph == 2'd2);

   always_ff @(posedge clk) begin
      if (rst)          ph <= 2'd0;
      else if (cyc_end) ph <= 2'd0;
      else              ph <= ph + 2'd1;
   end
endmodule

// File: rtl/dbp_cycle_ctr.sv
// Counts stage cycles within one output period.
module dbp_cycle_ctr #(
   parameter int CYC_W = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic full,       // all bits set: final stage cycle
   output logic upper       // second half of the period
);
   logic [CYC_W-1:0] cnt;

   assign full  = &cnt;
   assign upper = cnt[CYC_W-1];

   always_ff @(posedge clk) begin
      if (rst)      cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dbp_mode_ctl.sv
// Captures the settings at each boundary and forms the stage's mode line.
module dbp_mode_ctl (
   input  logic clk,
   input  logic rst,
   input  logic band_sel,
   input  logic mod_sel,
   input  logic boundary,
   input  logic last_cyc,
   output logic band_q,
   output logic mod_q,
   output logic stage_div2
);
   logic ctl;

   always_ff @(posedge clk) begin
      if (rst || boundary) begin
         band_q <= band_sel;
         mod_q  <= mod_sel;
      end
   end

   // The control line falls only in the final cycle, when the modulus is 0.
   assign ctl        = ~(last_cyc & ~mod_q);
   assign stage_div2 = band_q ? ~ctl : ctl;
endmodule

// File: rtl/dual_band_prescaler.sv
module dual_band_prescaler #(
   parameter int CYC_W = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic band_sel,
   input  logic mod_sel,
   output logic div_clk,
   output logic tc_pulse
);
   localparam int CYCLES = 1 << CYC_W;

   generate
      if (CYC_W < 2 || CYC_W > 12) begin : g_bad_cyc_w
         $error("dual_band_prescaler: CYC_W out of range");
      end
   endgenerate

   logic stage_div2, cyc_end, last_cyc, upper;
   logic sel_q, mod_q;

   dbp_stage23 u_stage (
      .clk(clk), .rst(rst), .div2(stage_div2), .cyc_end(cyc_end)
   );

   dbp_cycle_ctr #(.CYC_W(CYC_W)) u_cyc (
      .clk(clk), .rst(rst), .adv(cyc_end), .full(last_cyc), .upper(upper)
   );

   dbp_mode_ctl u_mode (
      .clk(clk), .rst(rst), .band_sel(band_sel), .mod_sel(mod_sel),
      .boundary(tc_pulse), .last_cyc(last_cyc),
      .band_q(sel_q), .mod_q(mod_q), .stage_div2(stage_div2)
   );

   assign tc_pulse = last_cyc & cyc_end;
   assign div_clk  = upper;
endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
   parameter int CYC_W = 4
) (
   input logic clk,
   input logic rst,
   input logic tc,
   input logic div_clk,
   input logic sel_q,
   input logic mod_q
);
   localparam int CYCLES = 1 << CYC_W;
   localparam int CNT_W  = $clog2(3 * CYCLES) + 1;

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || tc) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (rst)
      tc |-> (int'(cnt) == dbp_pkg::ratio(sel_q, mod_q, CYCLES) - 1)); // R1, R2, R3, R4
   AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
      tc |=> !tc); // R5
   AST_DIV_LOW_AFTER_TC: assert property (@(posedge clk) disable iff (rst)
      tc |=> !div_clk); // R6
   AST_SETTING_HOLD: assert property (@(posedge clk) disable iff (rst)
      !tc |=> ($stable(sel_q) && $stable(mod_q))); // R7
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!tc && !div_clk)); // R8
endmodule

bind dual_band_prescaler dbp_checker #(.CYC_W(CYC_W)) u_chk (
   .clk(clk), .rst(rst), .tc(tc_pulse), .div_clk(div_clk),
   .sel_q(sel_q), .mod_q(mod_q)
);

// File: tb/dual_band_prescaler_tb.sv
module dual_band_prescaler_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic band_sel = 1'b0;
   logic mod_sel = 1'b1;
   logic div_clk, tc_pulse;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      int    len;
      int    low;
      string tag;
   } exp_t;

   exp_t exp_q[$];

   always #2 clk = ~clk;

   dual_band_prescaler u_dut (
      .clk(clk), .rst(rst), .band_sel(band_sel), .mod_sel(mod_sel),
      .div_clk(div_clk), .tc_pulse(tc_pulse)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic exp_t make_exp(input logic s, input logic m, input string extra);
      exp_t e;
      string t;
      if (s) begin e.len = m ? 48 : 47; t = m ? "R4" : "R3"; end
      else   begin e.len = m ? 32 : 33; t = m ? "R1" : "R2"; end
      e.low = s ? 24 : 16;
      e.tag = {t, extra};
      return e;
   endfunction

   task automatic wait_tc();
      do begin
         @(posedge clk); #1;
      end while (!tc_pulse);
   endtask

   // Sets the settings for the next period during its terminal clock and
   // optionally disturbs them mid-period (R7).
   task automatic run_period(input logic s, input logic m, input bit mid,
                             input logic ms, input logic mm);
      wait_tc();
      band_sel = s;
      mod_sel  = m;
      exp_q.push_back(make_exp(s, m, mid ? " R7" : ""));
      if (mid) begin
         repeat (12) @(posedge clk);
         #1;
         band_sel = ms;
         mod_sel  = mm;
      end
   endtask

   // Monitor: scoreboard side
   int  cnt = 0;
   int  low = 0;
   bit  after_tc = 1'b0;
   bit  rst_prev = 1'b0;

   always @(negedge clk) begin
      if (rst) begin
         cnt = 0;
         low = 0;
         after_tc = 1'b0;
         if (rst_prev) begin
            chk(!tc_pulse, "R8 tc_pulse in reset", int'(tc_pulse), 0);
            chk(!div_clk, "R8 div_clk in reset", int'(div_clk), 0);
         end
      end else begin
         if (after_tc) chk(!tc_pulse, "R5 tc_pulse after terminal", int'(tc_pulse), 0);
         after_tc = 1'b0;
         cnt++;
         if (!div_clk) low++;
         if (tc_pulse) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected terminal pulse", cnt, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(cnt == e.len, {e.tag, " period length"}, cnt, e.len);
               chk(low == e.low, {e.tag, " R6 low clocks"}, low, e.low);
            end
            cnt = 0;
            low = 0;
            after_tc = 1'b1;
         end
      end
      rst_prev = rst;
   end

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R8: first period follows the settings held at reset release
      exp_q.push_back(make_exp(1'b0, 1'b1, " R8"));
      repeat (4) @(posedge clk);
      #1;
      rst = 1'b0;

      run_period(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_period(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_period(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      run_period(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      run_period(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      run_period(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_period(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      run_period(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      run_period(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // Mid-period reset: the pending period is abandoned (R8)
      wait_tc();
      repeat (7) @(posedge clk);
      #1;
      rst = 1'b1;
      band_sel = 1'b1;
      mod_sel  = 1'b0;
      exp_q.delete();
      exp_q.push_back(make_exp(1'b1, 1'b0, " R8"));
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;

      run_period(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_period(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      wait_tc();
      @(negedge clk);
      @(negedge clk);
      chk(exp_q.size() == 0, "R5 pending expectations", exp_q.size(), 0);
      finish_run();
   end
endmodule